// File: doc/BRIEF.md
# Microcoded Post-Accumulator ALU

This block sits after an accumulator and combines two signed operands, A and B, under the control of a 10-bit microcode word. The microcode word arrives from a register that the host loads elsewhere. The low seven bits choose the operation. When all three arithmetic select bits are clear, a 4-bit truth table in the word is applied to every bit pair of the operands, so any of the sixteen two-input bitwise functions is available. When exactly one select bit is set, the block adds or subtracts instead.

The top three microcode bits choose a shift that follows the operation. Right shifts copy the sign bit into the vacated positions. Left shifts fill with zeros and discard the bits that move out. The shifted value is captured in an output register on each rising clock edge. Reset clears that register to zero.

Both the datapath width and the number of shift stages are parameters. The operand logic is generated bit by bit, and the shifter is generated as one mux stage per bit of the shift amount.

Top module: `mc_post_alu`

## Requirements
- R1: While `rst` is high at a rising edge, `y` becomes zero on that edge.
- R2: `y` is registered. It shows the result for the `a`, `b` and `mc` values present at the previous rising edge, and it holds between edges.
- R3: With `mc[2:0]` = 000, each result bit comes from the truth table for its operand bit pair: `mc[6]` for (a,b)=(0,0), `mc[5]` for (0,1), `mc[4]` for (1,0) and `mc[3]` for (1,1).
- R4: All sixteen truth-table codes act as their bitwise functions. Examples are 0001 AND, 0111 OR, 0110 XOR, 1110 NAND, 1000 NOR, 1001 XNOR, 1100 NOT A, 1010 NOT B, 0000 zero and 1111 all ones.
- R5: With `mc[2:0]` = 001, the result is A+B modulo 2^20, and `mc[6:3]` has no effect.
- R6: With `mc[2:0]` = 010, the result is A−B. With 100, it is B−A. Both wrap modulo 2^20.
- R7: When two or more bits of `mc[2:0]` are set, the operation result is A, before any shift.
- R8: `mc[9:7]` codes 001, 010 and 011 shift the result right by 1, 2 and 3 places, copying bit 19 into the vacated positions.
- R9: `mc[9:7]` codes 100, 101 and 110 shift the result left by 1, 2 and 3 places, filling with zeros and dropping the bits shifted out.
- R10: `mc[9:7]` codes 000 and 111 leave the result unshifted.
- R11: Microcode 00_0001_1000 (binary 0000011000) passes A to `y` unchanged. This is the value the microcode register holds after its reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the output register |
| a | input | 20 | Operand A |
| b | input | 20 | Operand B |
| mc | input | 10 | Microcode word: shift code [9:7], truth table [6:3], arithmetic selects [2:0] |
| y | output | 20 | Registered result |

## Verification
The bench builds the block with its default parameters: a 20-bit datapath and two shift stages. With these values, the sign bit at position 19, the wrap of sums and differences past 2^20, and every one of the eight shift codes can be reached with directed operands. The bench sweeps all sixteen truth tables over operand pairs that contain every bit combination. It also drives each multi-hot arithmetic select, combines shifts with the arithmetic results, and checks that the output holds between edges and clears on a reset in the middle of a run.

// File: rtl/mc_alu_pkg.sv
package mc_alu_pkg;

   localparam int MC_W      = 10;
   localparam int SHCODE_W  = 3;
   localparam int TT_W      = 4;
   localparam int ARSEL_W   = 3;

   typedef struct packed {
      logic [SHCODE_W-1:0] shcode;
      logic [TT_W-1:0]     table4;
      logic [ARSEL_W-1:0]  arsel;
   } mc_word_t;

   localparam logic [ARSEL_W-1:0] AR_ADD   = 3'b001;
   localparam logic [ARSEL_W-1:0] AR_A_SUB = 3'b010;
   localparam logic [ARSEL_W-1:0] AR_B_SUB = 3'b100;

   // Shift decode: the top bit picks left, the low two bits give the amount.
   function automatic logic shift_is_left(input logic [SHCODE_W-1:0] c);
      return c[2] && (c[1:0] != 2'b11);
   endfunction

   function automatic logic [1:0] shift_amount(input logic [SHCODE_W-1:0] c);
      logic [1:0] amt;
      if (c == 3'b111)  amt = 2'd0;
      else if (c[2])    amt = c[1:0] + 2'd1;
      else              amt = c[1:0];
      return amt;
   endfunction

endpackage

// File: rtl/mc_alu_logic.sv
module mc_alu_logic #(
   parameter int DATA_W = 20
) (
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   input  logic [3:0]        table4,
   output logic [DATA_W-1:0] res
);

   generate
      if (DATA_W < 1) begin : g_bad_w
         $error("mc_alu_logic: DATA_W must be positive");
      end
   endgenerate

   // table4[3] answers (0,0), table4[0] answers (1,1)
   generate
      for (genvar i = 0; i < DATA_W; i++) begin : g_bit
         logic [1:0] pair_idx;
         assign pair_idx = {~opa[i], ~opb[i]};
         assign res[i]   = table4[pair_idx];
      end
   endgenerate

endmodule

// File: rtl/mc_alu_arith.sv
module mc_alu_arith #(
   parameter int DATA_W = 20
) (
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   input  logic [2:0]        arsel,
   output logic [DATA_W-1:0] res,
   output logic              arith_on
);
   import mc_alu_pkg::*;

   logic [DATA_W-1:0] sum_ab;
   logic [DATA_W-1:0] dif_ab;
   logic [DATA_W-1:0] dif_ba;

   assign sum_ab   = opa + opb;
   assign dif_ab   = opa - opb;
   assign dif_ba   = opb - opa;
   assign arith_on = (arsel != '0);

   always_comb begin
      unique case (arsel)
         AR_ADD:   res = sum_ab;
         AR_A_SUB: res = dif_ab;
         AR_B_SUB: res = dif_ba;
         default:  res = opa;   // none or several selects: pass A
      endcase
   end

endmodule

// File: rtl/mc_alu_shift.sv
module mc_alu_shift #(
   parameter int DATA_W   = 20,
   parameter int STAGES   = 2
) (
   input  logic [DATA_W-1:0] din,
   input  logic              go_left,
   input  logic [STAGES-1:0] amount,
   output logic [DATA_W-1:0] dout
);

   localparam int MAX_SH = (1 << STAGES) - 1;

   generate
      if (MAX_SH >= DATA_W) begin : g_bad_sh
         $error("mc_alu_shift: shift range must stay below DATA_W");
      end
   endgenerate

   logic [DATA_W-1:0] stage_q [STAGES+1];
   assign stage_q[0] = din;

   generate
      for (genvar k = 0; k < STAGES; k++) begin : g_stage
         localparam int D = 1 << k;
         logic [DATA_W-1:0] moved;
         always_comb begin
            if (go_left) moved = {stage_q[k][DATA_W-1-D:0], {D{1'b0}}};
            else         moved = {{D{stage_q[k][DATA_W-1]}}, stage_q[k][DATA_W-1:D]};
         end
         assign stage_q[k+1] = amount[k] ? moved : stage_q[k];
      end
   endgenerate

   assign dout = stage_q[STAGES];

endmodule

// File: rtl/mc_post_alu.sv
module mc_post_alu #(
   parameter int DATA_W = 20
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [19:0]       a,
   input  logic [19:0]       b,
   input  logic [9:0]        mc,
   output logic [19:0]       y
);
   import mc_alu_pkg::*;

   localparam int SH_STAGES = 2;

   generate
      if (DATA_W != 20) begin : g_bad_top
         $error("mc_post_alu: port widths are fixed at 20 bits");
      end
   endgenerate

   mc_word_t          mcw;
   logic [DATA_W-1:0] logic_res;
   logic [DATA_W-1:0] arith_res;
   logic              arith_on;
   logic [DATA_W-1:0] op_res;
   logic [DATA_W-1:0] sh_res;
   logic              sh_left;
   logic [1:0]        sh_amt;

   assign mcw = mc;

   mc_alu_logic #(.DATA_W(DATA_W)) u_logic (
      .opa    (a),
      .opb    (b),
      .table4 (mcw.table4),
      .res    (logic_res)
   );

   mc_alu_arith #(.DATA_W(DATA_W)) u_arith (
      .opa      (a),
      .opb      (b),
      .arsel    (mcw.arsel),
      .res      (arith_res),
      .arith_on (arith_on)
   );

   assign op_res  = arith_on ? arith_res : logic_res;
   assign sh_left = shift_is_left(mcw.shcode);
   assign sh_amt  = shift_amount(mcw.shcode);

   mc_alu_shift #(.DATA_W(DATA_W), .STAGES(SH_STAGES)) u_shift (
      .din     (op_res),
      .go_left (sh_left),
      .amount  (sh_amt),
      .dout    (sh_res)
   );

   always_ff @(posedge clk) begin
      if (rst) y <= '0;
      else     y <= sh_res;
   end

   // R1
   reset_clear_chk: assert property (@(posedge clk) rst |=> (y == '0));

   // R4
   xor_path_chk: assert property (@(posedge clk) disable iff (rst)
      (mc == 10'b000_0110_000) |=> (y == ($past(a) ^ $past(b))));

   // R5
   add_path_chk: assert property (@(posedge clk) disable iff (rst)
      (mc[9:7] == 3'b000 && mc[2:0] == 3'b001) |=> (y == 20'($past(a) + $past(b))));

   // R7
   multi_sel_chk: assert property (@(posedge clk) disable iff (rst)
      (mc[9:7] == 3'b000 && $countones(mc[2:0]) > 1) |=> (y == $past(a)));

   // R8
   sign_keep_chk: assert property (@(posedge clk) disable iff (rst)
      (mc == 10'b001_0011_000) |=> (y == {$past(a[19]), $past(a[19:1])}));

   // R9
   left_fill_chk: assert property (@(posedge clk) disable iff (rst)
      (mc[9] && mc[8:7] != 2'b11) |=> (y[0] == 1'b0));

   // R11
   default_pass_chk: assert property (@(posedge clk) disable iff (rst)
      (mc == 10'b0000011000) |=> (y == $past(a)));

endmodule

// File: tb/test_mc_post_alu.sv
`timescale 1ns/1ps
module test_mc_post_alu;

   localparam int W = 20;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] a   = '0;
   logic [W-1:0] b   = '0;
   logic [9:0]   mc  = 10'b0000011000;
   logic [W-1:0] y;

   int n_chk  = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   mc_post_alu i_mc_post_alu (
      .clk (clk), .rst (rst), .a (a), .b (b), .mc (mc), .y (y)
   );

   function automatic logic [W-1:0] model(input logic [W-1:0] xa,
                                          input logic [W-1:0] xb,
                                          input logic [9:0] m);
      logic [W-1:0] r;
      logic [3:0]   tt;
      int           sh;
      tt = m[6:3];
      case (m[2:0])
         3'b000: for (int i = 0; i < W; i++) begin
            if (xa[i] && xb[i])       r[i] = tt[0];
            else if (xa[i])           r[i] = tt[1];
            else if (xb[i])           r[i] = tt[2];
            else                      r[i] = tt[3];
         end
         3'b001:  r = xa + xb;
         3'b010:  r = xa - xb;
         3'b100:  r = xb - xa;
         default: r = xa;
      endcase
      sh = int'(m[9:7]);
      if (sh >= 1 && sh <= 3)      r = W'($signed(r) >>> sh);
      else if (sh >= 4 && sh <= 6) r = r << (sh - 3);
      return r;
   endfunction

   task automatic check(input string req, input logic [W-1:0] got,
                        input logic [W-1:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic run_op(input string req, input logic [W-1:0] xa,
                         input logic [W-1:0] xb, input logic [9:0] m);
      @(negedge clk);
      a = xa; b = xb; mc = m;
      @(posedge clk);
      #1;
      check(req, y, model(xa, xb, m));
   endtask

   task automatic t_reset;
      rst = 1'b1;
      a = 20'hFFFFF; b = 20'h12345; mc = 10'b000_0111_000;
      @(posedge clk); #1;
      check("R1 reset", y, '0);
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic t_logic;
      for (int t = 0; t < 16; t++) begin
         run_op("R3/R4 table", 20'hF0F0C, 20'hCC3A5, {3'b000, 4'(t), 3'b000});
         run_op("R4 table",    20'h5A5A5, 20'hFF00F, {3'b000, 4'(t), 3'b000});
      end
      // R3 single pair: a bit=0,b bit=1 selects mc[5]
      run_op("R3 pair01", 20'h00000, 20'hFFFFF, 10'b000_0100_000);
   endtask

   task automatic t_arith;
      run_op("R5 add",       20'h12345, 20'h0F0F1, 10'b000_0110_001);
      run_op("R5 add wrap",  20'hFFFFF, 20'h00003, 10'b000_1111_001);
      run_op("R5 tt ignore", 20'h12345, 20'h0F0F1, 10'b000_0000_001);
      run_op("R6 a-b",       20'h00005, 20'h00009, 10'b000_1001_010);
      run_op("R6 b-a",       20'h00005, 20'h00009, 10'b000_1001_100);
      run_op("R6 b-a pos",   20'h80000, 20'h80010, 10'b000_1001_100);
   endtask

   task automatic t_multi;
      run_op("R7 011", 20'hABCDE, 20'h11111, 10'b000_0110_011);
      run_op("R7 101", 20'hABCDE, 20'h11111, 10'b000_0000_101);
      run_op("R7 110", 20'hABCDE, 20'h11111, 10'b000_1111_110);
      run_op("R7 111", 20'hABCDE, 20'h11111, 10'b000_0001_111);
      run_op("R7 shifted", 20'h80001, 20'h0, 10'b101_0000_111);
   endtask

   task automatic t_shift;
      for (int s = 0; s < 8; s++) begin
         string tag;
         tag = (s == 0 || s == 7) ? "R10 none" : (s < 4) ? "R8 right" : "R9 left";
         run_op(tag, 20'h9A5C3, 20'h0, {3'(s), 7'b0011000});
         run_op(tag, 20'h7A5C3, 20'h0, {3'(s), 7'b0011000});
      end
      run_op("R8 sub shift", 20'h00000, 20'h00010, 10'b011_1001_010);
      run_op("R9 add shift", 20'hF0000, 20'h00001, 10'b110_0110_001);
   endtask

   task automatic t_default_and_hold;
      logic [W-1:0] prev;
      run_op("R11 default", 20'hC3A51, 20'h5555A, 10'b0000011000);
      prev = y;
      @(negedge clk);
      a = 20'h00001; b = 20'h00002; mc = 10'b000_0110_001;
      #1;
      check("R2 hold", y, prev);
      @(posedge clk); #1;
      check("R2 latency", y, 20'h00003);
   endtask

   task automatic t_mid_reset;
      run_op("R2 pre", 20'h0F00F, 20'h0, 10'b0000011000);
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk); #1;
      check("R1 mid reset", y, '0);
      @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin : watchdog
      #200000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      t_reset();
      t_logic();
      t_arith();
      t_multi();
      t_shift();
      t_default_and_hold();
      t_mid_reset();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule